// File: doc/BRIEF.md
# Successive-Approximation Converter Controller with Bus Interface

This block is the digital core of an 8-bit successive-approximation converter that hangs on a microprocessor bus. A host starts a conversion by pulling chip select and start low together. While both stay low the controller holds itself cleared. When either one is released, the controller waits for its free-running phase counter to line up and then resolves the code one bit at a time, MSB first. For each bit it presents a trial code to an external DAC and comparator and reads back a single decision bit.

When the last bit is decided, the whole code moves into an output latch in one step and the active-low interrupt falls. A read strobe with chip select low clears the interrupt. The same read strobe, together with chip select, enables the data outputs. The tri-state bus appears as a data word plus an enable. If a start arrives in the middle of a conversion, that conversion is dropped and the latch keeps the last finished code.

With chip select and read tied low and the interrupt wired back to start, the block converts without end. Each interrupt retriggers the next conversion.

Top module: `sar_bus_ctrl`

## Requirements
- R1: While `cs_n` and `wr_n` are both low (after two clocks of synchronization), `trial` is held at 0, `intr_n` is held high and no conversion proceeds, however long the condition lasts.
- R2: Count clock edges from the moment start is released. `intr_n` falls on an edge between 68 and 75 inclusive: 3 edges of sync and hand-off, 1 to 8 edges of phase alignment, and 64 edges of bit decisions.
- R3: `cmp_hi` = 1 means the input is at or above `trial`. The code latched at completion is the largest code not above the input, so with an ideal comparator it equals the input value. This holds at codes 0 and 255.
- R4: During a conversion exactly one bit is under test. All trial bits below it are 0, and bits are tested from MSB to LSB.
- R5: `dout` changes only on the edge where `intr_n` falls, at the end of a completed conversion.
- R6: `intr_n` falls only when a conversion completes. It stays low until a read clears it or a new start arrives.
- R7: The falling edge of the combined read condition (`cs_n` low and `rd_n` low) raises `intr_n` within 3 clocks. A read strobe while `cs_n` is high has no effect on `intr_n`.
- R8: `doe` is 1 exactly while `cs_n` and `rd_n` are both low. Otherwise the bus is released.
- R9: A start issued during a conversion abandons it. `dout` keeps the last completed code until a later conversion finishes.
- R10: With `cs_n` and `rd_n` low and `wr_n` driven by `intr_n`, a single low kick starts conversions that repeat without further stimulus.
- R11: After reset `intr_n` is 1, `dout` is 0 and `trial` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Start strobe, active low, asynchronous |
| rd_n | input | 1 | Output-enable / read strobe, active low |
| cmp_hi | input | 1 | Comparator decision: input at or above trial |
| trial | output | W | Trial code to the external DAC |
| dout | output | W | Output latch contents (bus data) |
| doe | output | 1 | Bus drive enable |
| intr_n | output | 1 | Result-ready interrupt, active low |

## Verification
A wrong decision bit or a misordered bit mask shows up as a mismatched code the moment `intr_n` falls. Each result is compared against the stored input value, so one bad bit fails that conversion. A corrupt phase counter or sync chain moves the interrupt outside the 68 to 75 edge window, which is measured on every directed conversion. A stale or spurious latch write shows as a `dout` change while a conversion is aborted or while the interrupt is already low, well before the next result would be due.

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl #(
  parameter int W        = 8,
  parameter int BIT_CLKS = 8,
  parameter int ALIGN    = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         wr_n,
  input  logic         rd_n,
  input  logic         cmp_hi,
  output logic [W-1:0] trial,
  output logic [W-1:0] dout,
  output logic         doe,
  output logic         intr_n
);
  localparam int SW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam int PW = (ALIGN > 1) ? $clog2(ALIGN) : 1;
  localparam logic [SW-1:0] SLOT_LAST = SW'(BIT_CLKS - 1);
  localparam logic [PW-1:0] PH_LAST   = PW'(ALIGN - 1);
  localparam logic [W-1:0]  MSB       = {1'b1, {(W-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_ALIGN, S_CONV} st_t;

  logic [1:0]    cs_q, wr_q, rd_q;
  logic          rd_seen;
  st_t           st;
  logic [PW-1:0] ph;
  logic [SW-1:0] slot;
  logic [W-1:0]  mask, sar, decided;
  logic          hold, rd_req, rd_pulse, conv, decide, last;

  assign hold     = !cs_q[1] && !wr_q[1];
  assign rd_req   = !cs_q[1] && !rd_q[1];
  assign rd_pulse = rd_req && !rd_seen;
  assign conv     = (st == S_CONV);
  assign decide   = conv && (slot == SLOT_LAST);
  assign last     = mask[0];
  assign decided  = cmp_hi ? sar : (sar & ~mask);
  assign trial    = sar;
  assign doe      = !cs_n && !rd_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= 2'b11;
      wr_q <= 2'b11;
      rd_q <= 2'b11;
      rd_seen <= 1'b0;
      ph <= '0;
    end else begin
      cs_q <= {cs_q[0], cs_n};
      wr_q <= {wr_q[0], wr_n};
      rd_q <= {rd_q[0], rd_n};
      rd_seen <= rd_req;
      ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      slot <= '0;
      mask <= '0;
      sar <= '0;
      dout <= '0;
      intr_n <= 1'b1;
    end else if (hold) begin
      st <= S_HOLD;
      slot <= '0;
      mask <= '0;
      sar <= '0;
      intr_n <= 1'b1;
    end else begin
      if (rd_pulse) intr_n <= 1'b1;
      case (st)
        S_HOLD: st <= S_ALIGN;
        S_ALIGN:
          if (ph == PH_LAST) begin
            st <= S_CONV;
            mask <= MSB;
            sar <= MSB;
            slot <= '0;
          end
        S_CONV:
          if (decide) begin
            slot <= '0;
            if (last) begin
              sar <= decided;
              dout <= decided;
              intr_n <= 1'b0;
              mask <= '0;
              st <= S_IDLE;
            end else begin
              mask <= mask >> 1;
              sar <= decided | (mask >> 1);
            end
          end else begin
            slot <= slot + 1'b1;
          end
        default: ;
      endcase
    end
endmodule

module sar_bus_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         hold,
  input logic         rd_pulse,
  input logic         conv,
  input logic [W-1:0] mask,
  input logic [W-1:0] trial,
  input logic [W-1:0] dout,
  input logic         intr_n
);
  p_hold_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (intr_n && trial == '0));

  p_one_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv |-> ($onehot(mask) && ((trial & (mask - W'(1))) == '0)));

  p_latch_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> (!intr_n && $past(conv)));

  p_intr_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(intr_n) |-> $past(conv));

  p_intr_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_n) |-> ($past(hold) || $past(rd_pulse)));
endmodule

bind sar_bus_ctrl sar_bus_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .rd_pulse(rd_pulse), .conv(conv),
  .mask(mask), .trial(trial), .dout(dout), .intr_n(intr_n)
);

// File: tb/sar_bus_ctrl_test.sv
module sar_bus_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_drv = 1'b1, rd_n = 1'b1;
  logic free = 1'b0, kick = 1'b0, free_chk = 1'b0;
  logic [7:0] vin = 8'h00;
  logic wr_n, cmp_hi, doe, intr_n;
  logic [7:0] trial, dout;
  int n_chk = 0, n_fail = 0, free_done = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign wr_n   = free ? (intr_n && !kick) : wr_drv;
  assign cmp_hi = (vin >= trial);

  sar_bus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .cmp_hi(cmp_hi), .trial(trial), .dout(dout), .doe(doe), .intr_n(intr_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic start_pulse();
    cs_n = 1'b0; wr_drv = 1'b0;
    tick(3);
    cs_n = 1'b1; wr_drv = 1'b1;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (intr_n && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_read(input int exp);
    cs_n = 1'b0; rd_n = 1'b0;
    tick(1);
    check(doe == 1'b1, "R8 doe on read", doe, 1);
    check(dout == exp[7:0], "R3 bus data", dout, exp);
    tick(2);
    check(intr_n == 1'b1, "R7 read clears intr", intr_n, 1);
    cs_n = 1'b1; rd_n = 1'b1;
    tick(1);
    check(doe == 1'b0, "R8 bus released", doe, 0);
  endtask

  task automatic convert(input logic [7:0] v);
    int n;
    vin = v;
    exp_q.push_back(int'(v));
    start_pulse();
    wait_done(n);
    check(n >= 68 && n <= 75, "R2 latency", n, 70);
    do_read(int'(v));
  endtask

  logic intr_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n && intr_prev && !intr_n) begin
      if (exp_q.size() > 0) begin
        int e;
        e = exp_q.pop_front();
        check(dout == e[7:0], "R3 result", dout, e);
      end else if (free_chk) begin
        free_done++;
        check(dout == vin, "R10 free-running result", dout, vin);
      end else begin
        check(1'b0, "R6 unexpected completion", 1, 0);
      end
    end
    intr_prev <= intr_n;
  end

  initial begin
    int n;
    logic [7:0] vals [8] = '{8'd0, 8'd255, 8'd128, 8'd127, 8'd85, 8'd170, 8'd1, 8'd254};
    tick(5);
    rst_n = 1'b1;
    tick(1);
    check(intr_n == 1'b1, "R11 intr after reset", intr_n, 1);
    check(dout == 8'd0, "R11 dout after reset", dout, 0);
    check(trial == 8'd0, "R11 trial after reset", trial, 0);
    check(doe == 1'b0, "R8 idle bus", doe, 0);

    foreach (vals[i]) convert(vals[i]);

    vin = 8'h5A;
    exp_q.push_back(32'h5A);
    start_pulse();
    wait_done(n);
    check(n >= 68 && n <= 75, "R2 latency", n, 70);
    rd_n = 1'b0;
    tick(6);
    check(intr_n == 1'b0, "R7 read ignored without select", intr_n, 0);
    check(doe == 1'b0, "R8 no drive without select", doe, 0);
    rd_n = 1'b1;
    tick(2);
    check(intr_n == 1'b0, "R6 intr stays low", intr_n, 0);

    vin = 8'hE7;
    exp_q.push_back(32'hE7);
    cs_n = 1'b0; wr_drv = 1'b0;
    tick(4);
    check(intr_n == 1'b1, "R6 new start clears intr", intr_n, 1);
    tick(150);
    check(intr_n == 1'b1, "R1 held in reset, intr", intr_n, 1);
    check(trial == 8'd0, "R1 held in reset, trial", trial, 0);
    check(dout == 8'h5A, "R1 latch unchanged during hold", dout, 32'h5A);
    cs_n = 1'b1; wr_drv = 1'b1;
    wait_done(n);
    check(n >= 68 && n <= 75, "R2 latency after long hold", n, 70);
    do_read(32'hE7);

    vin = 8'h33;
    start_pulse();
    tick(40);
    check(intr_n == 1'b1, "R9 conversion in flight", intr_n, 1);
    vin = 8'hC4;
    exp_q.push_back(32'hC4);
    start_pulse();
    tick(40);
    check(dout == 8'hE7, "R9 previous result kept", dout, 32'hE7);
    wait_done(n);
    check(n >= 28 && n <= 35, "R9 restarted conversion completes", n, 30);
    do_read(32'hC4);

    vin = 8'h9E;
    free_chk = 1'b1;
    cs_n = 1'b0; rd_n = 1'b0;
    free = 1'b1; kick = 1'b1;
    tick(4);
    kick = 1'b0;
    tick(500);
    check(free_done >= 5, "R10 repeated conversions", free_done, 5);
    check(doe == 1'b1, "R8 drive in free-running", doe, 1);
    free = 1'b0; wr_drv = 1'b1; cs_n = 1'b1; rd_n = 1'b1;
    tick(100);
    free_chk = 1'b0;
    check(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      check(1'b0, "R2 watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule